// File: doc/BRIEF.md
# Packed byte absolute-difference accumulator

This block measures how similar two 32-bit words are. Each word holds four unsigned bytes. For every byte position the block takes the absolute difference of the two bytes, then adds the four differences into one lane sum. Two single-word forms are available. The plain form returns the lane sum alone. The accumulating form adds a 32-bit operand taken from outside to the lane sum. A 4-bit selector code chooses between the two forms, and the all-ones code picks the plain form.

In block-matching work a long run of word pairs must be reduced to one score. For this the block offers a stream mode. In stream mode it keeps a running total inside, adds each accepted pair's lane sum to it and outputs the new total. A clear pulse starts a fresh score. Every result is registered and comes out one cycle after the pair is accepted, flagged by a valid output.

Top module: `packed_sad_acc`

## Requirements
- R1: Each input word is split into byte lanes at bits 31:24, 23:16, 15:8 and 7:0. Each lane's difference is taken as unsigned: larger byte minus smaller byte, giving 0 to 255.
- R2: With stream_en low and acc_sel equal to 4'b1111, the result is the sum of the four lane differences, a value from 0 to 1020.
- R3: With stream_en low and acc_sel other than 4'b1111, the result is acc_in plus the lane sum, wrapping modulo 2^32.
- R4: With stream_en high, each accepted pair adds its lane sum to an internal running total, wrapping modulo 2^32. The result is the updated total. acc_in and acc_sel have no effect in this mode.
- R5: A clear pulse sets the running total to zero. If clear comes in the same cycle as an accepted stream pair, the total becomes that pair's lane sum alone.
- R6: A pair is accepted in a cycle where in_valid is high. out_valid is high in the next cycle, and sum_out shows that pair's result in that cycle.
- R7: While in_valid is low, sum_out and the running total keep their values, and out_valid is low.
- R8: After reset, out_valid is 0, sum_out is 0 and the running total is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Accept the current word pair |
| word_a | input | 32 | First packed-byte word |
| word_b | input | 32 | Second packed-byte word |
| acc_sel | input | 4 | Accumulate selector; 4'b1111 = plain form |
| acc_in | input | 32 | External accumulator operand |
| stream_en | input | 1 | Accumulate into the internal running total |
| clear | input | 1 | Zero the running total |
| out_valid | output | 1 | sum_out holds a new result |
| sum_out | output | 32 | Registered result |

## Verification
Several input patterns are used. Identical words must give zero, which exposes any offset or stray carry. Words of all 0x00 against all 0xFF must give 1020, which exercises the largest lane value and the width of the adder tree. Pairs are also swapped so that word_b is larger in some lanes and smaller in others, which separates a true absolute difference from a plain subtraction and catches lanes that are missing or shifted. In the accumulating form, an operand near 2^32 shows the wrap, and nearby selector codes show that only all-ones picks the plain form. Runs in stream mode, with clear pulses, idle gaps and ignored acc_in values, check that the total is carried correctly from one pair to the next.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int unsigned LANES    = 4;
  localparam int unsigned LANE_W   = 8;
  localparam int unsigned WORD_W   = LANES * LANE_W;
  localparam int unsigned LSUM_W   = LANE_W + $clog2(LANES);
  localparam int unsigned SEL_W    = 4;
  localparam logic [SEL_W-1:0] SEL_PLAIN = '1;
endpackage

// File: rtl/sad_lane_diff.sv
module sad_lane_diff #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] lane_a,
  input  logic [W-1:0] lane_b,
  output logic [W-1:0] lane_diff
);
  logic [W:0] fwd;
  logic [W:0] rev;

  always_comb begin
    fwd = {1'b0, lane_a} - {1'b0, lane_b};
    rev = {1'b0, lane_b} - {1'b0, lane_a};
    // borrow out of the forward subtraction marks lane_a < lane_b
    lane_diff = fwd[W] ? rev[W-1:0] : fwd[W-1:0];
  end
endmodule

// File: rtl/sad_lane_sum.sv
module sad_lane_sum #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned SUM_W = LANE_W + $clog2(LANES)
) (
  input  logic [LANES*LANE_W-1:0] diffs,
  output logic [SUM_W-1:0]        lane_sum
);
  always_comb begin
    lane_sum = '0;
    for (int i = 0; i < LANES; i++) begin
      lane_sum = lane_sum + SUM_W'(diffs[i*LANE_W +: LANE_W]);
    end
  end
endmodule

// File: rtl/sad_acc_core.sv
module sad_acc_core #(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned SUM_W = 10,
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n_i,
  input  logic             in_valid,
  input  logic [SUM_W-1:0] lane_sum,
  input  logic [SEL_W-1:0] acc_sel,
  input  logic [ACC_W-1:0] acc_in,
  input  logic             stream_en,
  input  logic             clear,
  output logic             out_valid,
  output logic [ACC_W-1:0] sum_out
);
  localparam logic [SEL_W-1:0] PLAIN = '1;

  logic [ACC_W-1:0] total_q, total_d;
  logic [ACC_W-1:0] res_q, res_d;
  logic             vld_q, vld_d;
  logic [ACC_W-1:0] base;
  logic [ACC_W-1:0] sum_ext;

  always_comb begin
    sum_ext = ACC_W'(lane_sum);
    base    = clear ? '0 : total_q;
    total_d = base;
    res_d   = res_q;
    vld_d   = in_valid;
    if (in_valid) begin
      if (stream_en) begin
        total_d = base + sum_ext;
        res_d   = base + sum_ext;
      end else if (acc_sel == PLAIN) begin
        res_d = sum_ext;
      end else begin
        res_d = acc_in + sum_ext;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      total_q <= '0;
      res_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      total_q <= total_d;
      res_q   <= res_d;
      vld_q   <= vld_d;
    end
  end

  assign out_valid = vld_q;
  assign sum_out   = res_q;
endmodule

// File: rtl/packed_sad_acc.sv
module packed_sad_acc
  import sad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  input  logic [SEL_W-1:0]  acc_sel,
  input  logic [WORD_W-1:0] acc_in,
  input  logic              stream_en,
  input  logic              clear,
  output logic              out_valid,
  output logic [WORD_W-1:0] sum_out
);
  logic [1:0]              rst_sync;
  logic                    rst_n_i;
  logic [LANES*LANE_W-1:0] diffs;
  logic [LSUM_W-1:0]       lane_sum;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sad_lane_diff #(.W(LANE_W)) u_diff (
      .lane_a   (word_a[g*LANE_W +: LANE_W]),
      .lane_b   (word_b[g*LANE_W +: LANE_W]),
      .lane_diff(diffs[g*LANE_W +: LANE_W])
    );
  end

  sad_lane_sum #(.LANES(LANES), .LANE_W(LANE_W)) u_sum (
    .diffs   (diffs),
    .lane_sum(lane_sum)
  );

  sad_acc_core #(.ACC_W(WORD_W), .SUM_W(LSUM_W), .SEL_W(SEL_W)) u_core (
    .clk      (clk),
    .rst_n_i  (rst_n_i),
    .in_valid (in_valid),
    .lane_sum (lane_sum),
    .acc_sel  (acc_sel),
    .acc_in   (acc_in),
    .stream_en(stream_en),
    .clear    (clear),
    .out_valid(out_valid),
    .sum_out  (sum_out)
  );
endmodule

// File: rtl/packed_sad_acc_chk.sv
module packed_sad_acc_chk
  import sad_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] word_a,
  input logic [WORD_W-1:0] word_b,
  input logic [SEL_W-1:0]  acc_sel,
  input logic              stream_en,
  input logic              clear,
  input logic              out_valid,
  input logic [WORD_W-1:0] sum_out
);
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(sum_out)));

  a_r2_plain_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !stream_en && acc_sel == SEL_PLAIN) |=> (sum_out <= WORD_W'(LANES * 255)));

  a_r1_equal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !stream_en && acc_sel == SEL_PLAIN && word_a == word_b) |=> (sum_out == '0));

  a_r5_clear_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && stream_en && clear && word_a == word_b) |=> (sum_out == '0));

  a_r8_reset_idle: assert property (@(posedge clk)
    !rst_n |-> !out_valid);
endmodule

bind packed_sad_acc packed_sad_acc_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .word_a   (word_a),
  .word_b   (word_b),
  .acc_sel  (acc_sel),
  .stream_en(stream_en),
  .clear    (clear),
  .out_valid(out_valid),
  .sum_out  (sum_out)
);

// File: tb/packed_sad_acc_test.sv
`timescale 1ns/1ps
module packed_sad_acc_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] word_a, word_b, acc_in;
  logic [3:0]  acc_sel;
  logic        stream_en, clear;
  logic        out_valid;
  logic [31:0] sum_out;

  int tests = 0;
  int fails = 0;
  logic [31:0] ref_total;
  bit done = 1'b0;

  always #5 clk = ~clk;

  packed_sad_acc uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .word_a(word_a),
    .word_b(word_b), .acc_sel(acc_sel), .acc_in(acc_in),
    .stream_en(stream_en), .clear(clear), .out_valid(out_valid),
    .sum_out(sum_out)
  );

  function automatic logic [31:0] ref_sad(input logic [31:0] a, input logic [31:0] b);
    int s = 0;
    for (int i = 0; i < 4; i++) begin
      int x = int'(a[i*8 +: 8]);
      int y = int'(b[i*8 +: 8]);
      s += (x > y) ? x - y : y - x;
    end
    return 32'(s);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive one cycle at negedge, sample the registered result one clock later
  task automatic apply(input logic v, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] sel, input logic [31:0] acc,
                       input logic str, input logic clr);
    @(negedge clk);
    in_valid = v; word_a = a; word_b = b; acc_sel = sel; acc_in = acc;
    stream_en = str; clear = clr;
    @(negedge clk);
    in_valid = 1'b0; clear = 1'b0;
  endtask

  task automatic plain(input string req, input logic [31:0] a, input logic [31:0] b);
    apply(1'b1, a, b, 4'hF, 32'hDEAD_BEEF, 1'b0, 1'b0);
    check({req, " valid"}, {31'd0, out_valid}, 32'd1);
    check(req, sum_out, ref_sad(a, b));
  endtask

  task automatic accum(input string req, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] sel, input logic [31:0] acc);
    apply(1'b1, a, b, sel, acc, 1'b0, 1'b0);
    check(req, sum_out, acc + ref_sad(a, b));
  endtask

  task automatic stream(input string req, input logic [31:0] a, input logic [31:0] b,
                        input logic clr);
    apply(1'b1, a, b, 4'($urandom), $urandom, 1'b1, clr);
    ref_total = (clr ? 32'd0 : ref_total) + ref_sad(a, b);
    check(req, sum_out, ref_total);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 1'b0; word_a = '0; word_b = '0;
    acc_sel = 4'hF; acc_in = '0; stream_en = 1'b0; clear = 1'b0;
    ref_total = '0;
    repeat (3) @(negedge clk);
    check("R8 reset valid", {31'd0, out_valid}, 32'd0);
    check("R8 reset sum", sum_out, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8: running total starts at zero
    stream("R8 total from zero", 32'h0000_0010, 32'h0000_0000, 1'b0);
    check("R8 first stream", sum_out, 32'd16);
    ref_total = 32'd16;

    // R1/R2 directed corners
    plain("R1 equal words", 32'hA5A5_5A5A, 32'hA5A5_5A5A);
    plain("R2 max 1020", 32'h0000_0000, 32'hFFFF_FFFF);
    check("R2 max value", sum_out, 32'd1020);
    plain("R1 mixed lanes", 32'h0102_0304, 32'h0403_0201);
    check("R1 mixed value", sum_out, 32'd8);
    plain("R1 top lane only", 32'h8000_0000, 32'h0000_0000);
    check("R1 top lane value", sum_out, 32'd128);
    plain("R1 swapped top lane", 32'h0000_0000, 32'h0000_0080);
    for (int i = 0; i < 150; i++) plain("R2 random", $urandom, $urandom);

    // R3 accumulating form
    accum("R3 wrap", 32'h0000_0001, 32'h0000_0000, 4'h0, 32'hFFFF_FFFF);
    check("R3 wrap value", sum_out, 32'd0);
    accum("R3 sel 1110", 32'h00FF_0000, 32'h0000_0000, 4'hE, 32'd100);
    check("R3 sel 1110 value", sum_out, 32'd355);
    accum("R3 sel 0111", 32'h0000_0003, 32'h0000_0007, 4'h7, 32'd1);
    for (int i = 0; i < 150; i++)
      accum("R3 random", $urandom, $urandom, 4'($urandom % 15), $urandom);

    // R4/R5 stream mode
    stream("R5 clear restart", 32'h1111_1111, 32'h0000_0000, 1'b1);
    check("R5 clear value", sum_out, 32'h44);
    for (int i = 0; i < 40; i++) stream("R4 stream run", $urandom, $urandom, 1'b0);
    stream("R5 clear equal", 32'h7777_7777, 32'h7777_7777, 1'b1);
    check("R5 clear equal value", sum_out, 32'd0);

    // R5 clear without a pair
    apply(1'b0, 32'h0, 32'h0, 4'hF, 32'h0, 1'b1, 1'b1);
    stream("R5 clear alone", 32'h0000_0005, 32'h0000_0000, 1'b0);
    ref_total = 32'd5;
    check("R5 clear alone value", sum_out, 32'd5);

    // R7 idle cycles hold result and total
    apply(1'b0, $urandom, $urandom, 4'h0, $urandom, 1'b1, 1'b0);
    check("R7 idle valid low", {31'd0, out_valid}, 32'd0);
    check("R7 idle sum held", sum_out, 32'd5);
    repeat (3) apply(1'b0, $urandom, $urandom, 4'hF, $urandom, 1'b0, 1'b0);
    check("R7 idle sum still held", sum_out, 32'd5);
    // plain word between stream words leaves total untouched
    plain("R7 plain between", 32'h0000_0009, 32'h0000_0000);
    stream("R7 total kept", 32'h0000_0002, 32'h0000_0000, 1'b0);
    check("R7 total kept value", sum_out, 32'd7);
    for (int i = 0; i < 30; i++) begin
      if (i % 4 == 0) apply(1'b0, 32'h0, 32'h0, 4'hF, 32'h0, 1'b1, 1'b0);
      stream("R4 stream gaps", $urandom, $urandom, 1'b0);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule